// File: doc/BRIEF.md
# Programmable Memory Chip-Select and Wait-State Generator

This block watches every bus cycle that a processor or a DMA master starts, decodes the cycle address against three programmed memory areas, and drives one of six active-low chip selects. The three areas are a top-of-memory area, a bottom-of-memory area and a relocatable midrange area. The midrange area is split into four equal sub-blocks, and each sub-block has its own select. The block also counts wait states for the area that was hit, and can combine that count with an external ready line. Slow memories can therefore be attached without separate ready logic. Address bits 1 and 2 are captured at cycle start and held for the length of the cycle.

The address, the memory/I-O qualifier and the area configuration are sampled when `cyc_start` is seen while no cycle is active. The selects, the latched address bits and the wait parameters then stay fixed until `cyc_end`. Configuration writes take effect from the next cycle start. After reset only the top area is enabled, at 1 KB with 3 wait states, so that the boot fetch near the top of the address space can proceed.

The controller has three states. IDLE moves to COUNT on a start when the wait count is non-zero, and to READY on a start when the count is zero. COUNT moves to READY when the counter reaches its last wait, and to IDLE on an end. READY moves to IDLE on an end.

Top module: `csel_unit`

## Requirements
- R1: Reset state. After reset all six selects are high, `rdy` is low, and `a1_q` and `a2_q` are low. The top area is enabled with size exponent `BOOT_SIZE_LOG2` (default 10), `BOOT_WAITS` wait states (default 3) and external ready not honoured. The bottom and midrange areas are disabled.
- R2: Top area. With exponent k, a memory cycle whose address has all bits from k upward set drives `ucs_n` low. The select goes low in the cycle after the accepted start edge and returns high in the cycle after the end edge.
- R3: Bottom area. With exponent k, a memory cycle whose address has all bits from k upward clear drives `lcs_n` low, with the same timing as R2.
- R4: Midrange area. With base B and exponent k, a memory cycle with B <= addr < B + 2^k drives `mcs_n[i]` low, where i = (addr - B) >> (k - 2). An exponent below 2 is treated as 2.
- R5: At most one select is low at a time. If areas overlap, the top area wins over the bottom area, and the bottom area wins over the midrange area. A disabled area never selects. An I/O cycle (`is_mem` = 0) selects nothing.
- R6: Wait count. When the hit area has W wait states, `rdy` is low for the W clock cycles after the start edge and rises in the following cycle. It stays high until the end edge.
- R7: External ready. When the hit area honours external ready, or when no area is hit, `rdy` is high only when the wait count has expired and `ext_rdy` is high. This path is combinational from `ext_rdy`. A cycle that hits no area has zero wait states.
- R8: `a1_q` and `a2_q` take address bits 1 and 2 at the accepted start. They, and the selects, keep their values until the end even if the address changes.
- R9: A start seen during an active cycle is ignored, and an end seen while idle is ignored. A configuration write during an active cycle does not change that cycle's wait count.
- R10: Configuration write format. `cfg_sel` picks the area: 0 top, 1 bottom, 2 midrange, 3 none. In `cfg_wdata`, bit 0 is enable, bits 2:1 are the wait count, bit 3 selects honouring of external ready, bits 8:4 are the size exponent, and bits ADDR_W+11:12 are the midrange base. The base field is used for area 2 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Bus cycle start strobe, address valid |
| cyc_end | input | 1 | Bus cycle end strobe |
| is_mem | input | 1 | 1 for a memory cycle, 0 for I/O |
| addr | input | ADDR_W | Cycle address |
| ext_rdy | input | 1 | External ready |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Area written: 0 top, 1 bottom, 2 midrange |
| cfg_wdata | input | ADDR_W+12 | Configuration word (format in R10) |
| ucs_n | output | 1 | Top area select, active low |
| lcs_n | output | 1 | Bottom area select, active low |
| mcs_n | output | 4 | Midrange sub-block selects, active low |
| rdy | output | 1 | Ready to the bus master |
| a1_q | output | 1 | Latched address bit 1 |
| a2_q | output | 1 | Latched address bit 2 |

## Verification
The bench builds the block with ADDR_W = 12 and keeps the default boot size of 1 KB and 3 wait states. With a 4 KB address space, every address can be swept through a full start-wait-end cycle under each of four configurations. Those configurations cover the boot setting, disjoint areas with wait counts 0 to 2, top-over-midrange overlap with the bottom area disabled, and bottom-over-midrange overlap with a clamped 4-byte midrange and honoured external ready. Each address is also checked for ready timing in every wait cycle, for latch retention under a changed address and a repeated start, and for release after the end strobe. A sparse sweep of I/O cycles and a directed case that rewrites the configuration mid-cycle complete the set.

// File: rtl/csel_pkg.sv
package csel_pkg;

    localparam int WAIT_W   = 2;
    localparam int SIZE_W   = 5;
    localparam int NUM_RG   = 3;

    // configuration word field positions
    localparam int FLD_EN   = 0;
    localparam int FLD_WAIT = 1;
    localparam int FLD_EXT  = 3;
    localparam int FLD_SIZE = 4;
    localparam int FLD_BASE = 12;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_READY = 2'd2
    } cyc_state_e;

    typedef enum logic [1:0] {
        RG_NONE  = 2'd0,
        RG_UPPER = 2'd1,
        RG_LOWER = 2'd2,
        RG_MID   = 2'd3
    } region_e;

    typedef struct packed {
        logic              en;
        logic [WAIT_W-1:0] waits;
        logic              use_ext;
        logic [SIZE_W-1:0] size_log2;
    } region_cfg_t;

endpackage

// File: rtl/csel_decode.sv
module csel_decode
    import csel_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_mem,
    input  region_cfg_t       up_cfg,
    input  region_cfg_t       lo_cfg,
    input  region_cfg_t       mid_cfg,
    input  logic [ADDR_W-1:0] mid_base,
    output region_e           hit,
    output logic [1:0]        sub,
    output logic [WAIT_W-1:0] waits,
    output logic              use_ext
);

    logic              up_hit, lo_hit, mid_hit;
    logic [ADDR_W-1:0] inv_addr, off, sub_full;
    logic [SIZE_W-1:0] mid_k;

    always_comb begin
        inv_addr = ~addr;
        up_hit   = is_mem && up_cfg.en && ((inv_addr >> up_cfg.size_log2) == '0);
        lo_hit   = is_mem && lo_cfg.en && ((addr >> lo_cfg.size_log2) == '0);
        off      = addr - mid_base;
        mid_k    = (mid_cfg.size_log2 < SIZE_W'(2)) ? SIZE_W'(2) : mid_cfg.size_log2;
        mid_hit  = is_mem && mid_cfg.en && (addr >= mid_base) && ((off >> mid_k) == '0);
        sub_full = off >> (mid_k - SIZE_W'(2));
        sub      = sub_full[1:0];

        if (up_hit) begin
            hit = RG_UPPER; waits = up_cfg.waits;  use_ext = up_cfg.use_ext;
        end else if (lo_hit) begin
            hit = RG_LOWER; waits = lo_cfg.waits;  use_ext = lo_cfg.use_ext;
        end else if (mid_hit) begin
            hit = RG_MID;   waits = mid_cfg.waits; use_ext = mid_cfg.use_ext;
        end else begin
            hit = RG_NONE;  waits = '0;            use_ext = 1'b1;
        end
    end

endmodule

// File: rtl/csel_ctrl.sv
module csel_ctrl
    import csel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic              cyc_end,
    input  region_e           hit,
    input  logic [1:0]        sub,
    input  logic [WAIT_W-1:0] waits,
    input  logic              use_ext,
    input  logic [1:0]        a21,
    input  logic              ext_rdy,
    output logic              ucs_n,
    output logic              lcs_n,
    output logic [3:0]        mcs_n,
    output logic              rdy,
    output logic              a1_q,
    output logic              a2_q
);

    cyc_state_e        st_q, st_d;
    logic [WAIT_W-1:0] cnt_q;
    region_e           rg_q;
    logic [1:0]        sub_q;
    logic              ext_q;
    logic [1:0]        a_q;
    logic              accept;

    assign accept = (st_q == ST_IDLE) && cyc_start;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (cyc_start) st_d = (waits == '0) ? ST_READY : ST_COUNT;
            ST_COUNT: if (cyc_end) st_d = ST_IDLE;
                      else if (cnt_q == WAIT_W'(1)) st_d = ST_READY;
            ST_READY: if (cyc_end) st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            rg_q  <= RG_NONE;
            sub_q <= '0;
            ext_q <= 1'b0;
            a_q   <= '0;
        end else if (accept) begin
            cnt_q <= waits;
            rg_q  <= hit;
            sub_q <= sub;
            ext_q <= use_ext;
            a_q   <= a21;
        end else if (st_q != ST_IDLE && cyc_end) begin
            rg_q  <= RG_NONE;
        end else if (st_q == ST_COUNT) begin
            cnt_q <= cnt_q - WAIT_W'(1);
        end
    end

    always_comb begin
        ucs_n = (rg_q != RG_UPPER);
        lcs_n = (rg_q != RG_LOWER);
        rdy   = (st_q == ST_READY) && (!ext_q || ext_rdy);
        a1_q  = a_q[0];
        a2_q  = a_q[1];
    end

    for (genvar g = 0; g < 4; g++) begin : g_mcs
        assign mcs_n[g] = !((rg_q == RG_MID) && (sub_q == 2'(g)));
    end

    AST_ONE_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~{ucs_n, lcs_n, mcs_n})); // R5

    AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE) |-> (&{ucs_n, lcs_n, mcs_n} && !rdy)); // R2

    AST_HOLD_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && !cyc_end) |=> $stable({ucs_n, lcs_n, mcs_n, a2_q, a1_q})); // R8

    AST_WAIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && cyc_start && waits != '0) |=> !rdy); // R6

    AST_END_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE && cyc_end) |=> (&{ucs_n, lcs_n, mcs_n} && !rdy)); // R9

endmodule

// File: rtl/csel_unit.sv
module csel_unit
    import csel_pkg::*;
#(
    parameter int ADDR_W         = 20,
    parameter int BOOT_SIZE_LOG2 = 10,
    parameter int BOOT_WAITS     = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cyc_start,
    input  logic                       cyc_end,
    input  logic                       is_mem,
    input  logic [ADDR_W-1:0]          addr,
    input  logic                       ext_rdy,
    input  logic                       cfg_we,
    input  logic [1:0]                 cfg_sel,
    input  logic [FLD_BASE+ADDR_W-1:0] cfg_wdata,
    output logic                       ucs_n,
    output logic                       lcs_n,
    output logic [3:0]                 mcs_n,
    output logic                       rdy,
    output logic                       a1_q,
    output logic                       a2_q
);

    localparam region_cfg_t BOOT_CFG = '{
        en:        1'b1,
        waits:     WAIT_W'(BOOT_WAITS),
        use_ext:   1'b0,
        size_log2: SIZE_W'(BOOT_SIZE_LOG2)
    };
    localparam int MID_IDX = 2;

    region_cfg_t       wr_cfg;
    logic [ADDR_W-1:0] base_q;

    always_comb begin
        wr_cfg.en        = cfg_wdata[FLD_EN];
        wr_cfg.waits     = cfg_wdata[FLD_WAIT +: WAIT_W];
        wr_cfg.use_ext   = cfg_wdata[FLD_EXT];
        wr_cfg.size_log2 = cfg_wdata[FLD_SIZE +: SIZE_W];
    end

    for (genvar g = 0; g < NUM_RG; g++) begin : g_cfg
        localparam region_cfg_t RST_CFG = (g == 0) ? BOOT_CFG : region_cfg_t'('0);
        region_cfg_t q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                              q <= RST_CFG;
            else if (cfg_we && cfg_sel == 2'(g))     q <= wr_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                  base_q <= '0;
        else if (cfg_we && cfg_sel == 2'(MID_IDX))   base_q <= cfg_wdata[FLD_BASE +: ADDR_W];
    end

    region_e           hit;
    logic [1:0]        sub;
    logic [WAIT_W-1:0] waits;
    logic              use_ext;

    csel_decode #(.ADDR_W(ADDR_W)) u_decode (
        .addr     (addr),
        .is_mem   (is_mem),
        .up_cfg   (g_cfg[0].q),
        .lo_cfg   (g_cfg[1].q),
        .mid_cfg  (g_cfg[2].q),
        .mid_base (base_q),
        .hit      (hit),
        .sub      (sub),
        .waits    (waits),
        .use_ext  (use_ext)
    );

    csel_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .cyc_end   (cyc_end),
        .hit       (hit),
        .sub       (sub),
        .waits     (waits),
        .use_ext   (use_ext),
        .a21       (addr[2:1]),
        .ext_rdy   (ext_rdy),
        .ucs_n     (ucs_n),
        .lcs_n     (lcs_n),
        .mcs_n     (mcs_n),
        .rdy       (rdy),
        .a1_q      (a1_q),
        .a2_q      (a2_q)
    );

endmodule

// File: tb/csel_unit_bench.sv
module csel_unit_bench;

    localparam int AW = 12;
    localparam int DW = AW + 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cyc_start = 1'b0, cyc_end = 1'b0, is_mem = 1'b1, ext_rdy = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = '0;
    logic [DW-1:0] cfg_wdata = '0;
    logic          ucs_n, lcs_n, rdy, a1_q, a2_q;
    logic [3:0]    mcs_n;

    int n_chk = 0;
    int n_bad = 0;

    // bench mirror of the programmed areas: 0 top, 1 bottom, 2 midrange
    int m_en[3], m_w[3], m_ex[3], m_k[3];
    int m_base;

    always #10 clk = ~clk;

    csel_unit #(.ADDR_W(AW)) u_csel_unit (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_end(cyc_end),
        .is_mem(is_mem), .addr(addr), .ext_rdy(ext_rdy), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .ucs_n(ucs_n), .lcs_n(lcs_n),
        .mcs_n(mcs_n), .rdy(rdy), .a1_q(a1_q), .a2_q(a2_q)
    );

    function automatic int sel_vec();
        return {26'd0, ucs_n, lcs_n, mcs_n};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // expected decode from R2..R5 and R7
    task automatic expect_of(input int a, input bit m, output int vec, output int w,
                             output int ex, output string req);
        int km;
        km  = (m_k[2] < 2) ? 2 : m_k[2];
        vec = 'h3f; w = 0; ex = 1; req = "R5";
        if (!m) begin
            vec = 'h3f;
        end else if (m_en[0] != 0 && a >= (1 << AW) - (1 << m_k[0])) begin
            vec = 'h1f; w = m_w[0]; ex = m_ex[0]; req = "R2";
        end else if (m_en[1] != 0 && a < (1 << m_k[1])) begin
            vec = 'h2f; w = m_w[1]; ex = m_ex[1]; req = "R3";
        end else if (m_en[2] != 0 && a >= m_base && a < m_base + (1 << km)) begin
            vec = 'h3f & ~(1 << ((a - m_base) >> (km - 2)));
            w = m_w[2]; ex = m_ex[2]; req = "R4";
        end
    endtask

    task automatic write_cfg(input int sel, input int en, input int w, input int ex,
                             input int k, input int base);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(sel);
        cfg_wdata = {AW'(base), 3'b000, 5'(k), 1'(ex), 2'(w), 1'(en)};  // R10
        @(negedge clk);
        cfg_we = 1'b0;
        m_en[sel] = en; m_w[sel] = w; m_ex[sel] = ex; m_k[sel] = k;
        if (sel == 2) m_base = base;
    endtask

    task automatic run(input int a, input bit m);
        int vec, w, ex;
        string req;
        expect_of(a, m, vec, w, ex, req);
        @(negedge clk);
        addr = AW'(a); is_mem = m; cyc_start = 1'b1; ext_rdy = 1'b0;
        @(negedge clk);
        cyc_start = 1'b0;
        chk(sel_vec() == vec, req, sel_vec(), vec);
        chk({a2_q, a1_q} == 2'((a >> 1) & 3), "R8", {a2_q, a1_q}, (a >> 1) & 3);
        addr = ~AW'(a); cyc_start = 1'b1;          // R9: ignored restart
        for (int i = 0; i <= w; i++) begin
            if (i > 0) @(negedge clk);
            if (i < w) chk(rdy == 1'b0, "R6", rdy, 0);
            else if (ex != 0) begin
                chk(rdy == 1'b0, "R7", rdy, 0);
                ext_rdy = 1'b1; #1;
                chk(rdy == 1'b1, "R7", rdy, 1);
            end else chk(rdy == 1'b1, "R6", rdy, 1);
        end
        @(negedge clk);
        cyc_start = 1'b0;
        chk(sel_vec() == vec && {a2_q, a1_q} == 2'((a >> 1) & 3), "R8/R9", sel_vec(), vec);
        cyc_end = 1'b1;
        @(negedge clk);
        cyc_end = 1'b0; ext_rdy = 1'b0;
        chk(sel_vec() == 'h3f && rdy == 1'b0, "R2", sel_vec(), 'h3f);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_en = '{1, 0, 0}; m_w = '{3, 0, 0}; m_ex = '{0, 0, 0}; m_k = '{10, 0, 0};
        m_base = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sel_vec() == 'h3f, "R1", sel_vec(), 'h3f);
        chk(rdy == 1'b0 && a1_q == 1'b0 && a2_q == 1'b0, "R1", {rdy, a2_q, a1_q}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sel_vec() == 'h3f && rdy == 1'b0, "R1", sel_vec(), 'h3f);

        // R1: boot configuration sweep
        for (int a = 0; a < (1 << AW); a++) run(a, 1'b1);

        // R9: end while idle ignored, then config rewrite mid-cycle
        @(negedge clk); cyc_end = 1'b1;
        @(negedge clk); cyc_end = 1'b0;
        chk(sel_vec() == 'h3f && rdy == 1'b0, "R9", sel_vec(), 'h3f);
        addr = AW'('hfff); is_mem = 1'b1; cyc_start = 1'b1;
        @(negedge clk);
        cyc_start = 1'b0;
        chk(sel_vec() == 'h1f, "R9", sel_vec(), 'h1f);
        cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = {AW'(0), 3'b000, 5'd10, 1'b0, 2'd0, 1'b1};
        chk(rdy == 1'b0, "R9", rdy, 0);
        @(negedge clk); cfg_we = 1'b0;
        chk(rdy == 1'b0, "R9", rdy, 0);
        @(negedge clk);
        chk(rdy == 1'b0, "R9", rdy, 0);
        @(negedge clk);
        chk(rdy == 1'b1, "R9", rdy, 1);
        cyc_end = 1'b1;
        @(negedge clk); cyc_end = 1'b0;
        m_w[0] = 0;
        run('hfff, 1'b1);

        // disjoint areas
        write_cfg(0, 1, 0, 0, 8, 0);
        write_cfg(1, 1, 1, 0, 9, 0);
        write_cfg(2, 1, 2, 0, 10, 'h400);
        for (int a = 0; a < (1 << AW); a++) run(a, 1'b1);
        for (int a = 0; a < (1 << AW); a += 16) run(a, 1'b0);   // R5 I/O cycles

        // top over midrange, bottom disabled
        write_cfg(0, 1, 1, 0, 9, 0);
        write_cfg(1, 0, 2, 0, 11, 0);
        write_cfg(2, 1, 0, 0, 10, 'hc00);
        for (int a = 0; a < (1 << AW); a++) run(a, 1'b1);

        // bottom over clamped midrange, external ready honoured, top disabled
        write_cfg(0, 0, 0, 0, 12, 0);
        write_cfg(1, 1, 2, 1, 11, 0);
        write_cfg(2, 1, 3, 1, 1, 'h7fe);
        for (int a = 0; a < (1 << AW); a++) run(a, 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule